// File: doc/BRIEF.md
# Header Word Serializer

This block takes a wide header vector, built from a fixed number of equal-width named fields, and sends it out as a short frame of datapath-width words. It sits in front of a concatenator that places the header ahead of a merged payload packet. The header is captured on a one-cycle valid strobe that coincides with the start of that payload packet. The block keeps the header until every word has been accepted by the downstream side.

Each field takes its value from one of two sources. A compile-time select mask picks the source per field: a clear bit takes the field from the datapath vector, and a set bit takes it from a local register written over a simple register bus. Register-sourced values are sampled at the moment of capture. While a captured header is still being sent, the block drops its sink ready and ignores further strobes. The first header offered for a packet is therefore the one that is sent.

Top module: `hdr_word_serializer`

## Requirements
- R1: After reset the source is idle (`src_valid`=0), `hdr_ready`=1, `reg_rdata`=0, and every field register reads 0.
- R2: A `hdr_valid` pulse while `hdr_ready`=1 captures the header, and `src_valid` rises on the next cycle.
- R3: A frame has ceil(NF*FIELD_W/DATA_W) words (3 at the defaults). Field 0 occupies the most significant bits of word 0, and field NF-1 follows at the least significant end. Zero padding fills the low bits of the last word. `src_sop` marks word 0 and `src_eop` marks the last word.
- R4: A field whose bit in SRC_MASK is 1 carries its register value; a field whose bit is 0 carries its slice of `hdr_in`. The default mask is 4'b1010, so fields 1 and 3 come from registers.
- R5: While `src_valid`=1 and `src_ready`=0, `src_data`, `src_sop` and `src_eop` hold their values and `src_valid` stays 1.
- R6: `hdr_ready` is 0 from capture until the last word is accepted. A strobe in that window has no effect on the frame being sent.
- R7: A register read (`reg_rd`=1, field index on `reg_addr`) returns that field's register value on `reg_rdata` one cycle later.
- R8: Writes to a field whose mask bit is 0 are ignored, and that field's register reads 0.
- R9: A register write after capture does not alter the frame in flight; it applies from the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hdr_in | input | NF*FIELD_W | Header fields, field 0 at the top |
| hdr_valid | input | 1 | One-cycle capture strobe |
| hdr_ready | output | 1 | Block can capture a header |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | max(1,$clog2(NF)) | Field index |
| reg_wdata | input | FIELD_W | Write value |
| reg_rdata | output | FIELD_W | Read value, one cycle after `reg_rd` |
| src_data | output | DATA_W | Header word |
| src_valid | output | 1 | Word present |
| src_ready | input | 1 | Downstream accepts the word |
| src_sop | output | 1 | First word of the header frame |
| src_eop | output | 1 | Last word of the header frame |

## Verification
The case that is hardest to reach from the ports is a new strobe or a register write landing while a frame is stalled halfway. The stimulus holds `src_ready` low after capture. During that stall it offers a second, different header and writes new values into the register-sourced fields. It then releases `src_ready` and checks that the words still carry the first header and the old register values. The next frame is checked to carry the new register values.

// File: rtl/hdr_word_serializer.sv
module hdr_word_serializer #(
  parameter int DATA_W   = 16,
  parameter int FIELD_W  = 10,
  parameter int NF       = 4,
  parameter logic [NF-1:0] SRC_MASK = 4'b1010,
  localparam int HDR_W   = NF * FIELD_W,
  localparam int WORDS   = (HDR_W + DATA_W - 1) / DATA_W,
  localparam int PAD_W   = WORDS * DATA_W,
  localparam int AW      = (NF > 1) ? $clog2(NF) : 1,
  localparam int CW      = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HDR_W-1:0]  hdr_in,
  input  logic              hdr_valid,
  output logic              hdr_ready,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [AW-1:0]     reg_addr,
  input  logic [FIELD_W-1:0] reg_wdata,
  output logic [FIELD_W-1:0] reg_rdata,
  output logic [DATA_W-1:0] src_data,
  output logic              src_valid,
  input  logic              src_ready,
  output logic              src_sop,
  output logic              src_eop
);
  localparam logic [CW-1:0] LAST = CW'(WORDS - 1);

  logic [FIELD_W-1:0] regs [NF];
  logic [HDR_W-1:0]   merged;
  logic [PAD_W-1:0]   held;
  logic [DATA_W-1:0]  words [WORDS];
  logic [CW-1:0]      cnt;
  logic               busy;

  for (genvar i = 0; i < NF; i++) begin : g_field
    localparam int HI = HDR_W - 1 - i * FIELD_W;
    if (SRC_MASK[i]) begin : g_reg
      assign merged[HI -: FIELD_W] = regs[i];
      always_ff @(posedge clk)
        if (rst) regs[i] <= '0;
        else if (reg_wr && 32'(reg_addr) == i) regs[i] <= reg_wdata;
    end else begin : g_dp
      assign merged[HI -: FIELD_W] = hdr_in[HI -: FIELD_W];
      assign regs[i] = '0;
    end
  end

  for (genvar k = 0; k < WORDS; k++) begin : g_word
    assign words[k] = held[PAD_W - 1 - k * DATA_W -: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      held <= '0;
    end else if (!busy) begin
      if (hdr_valid) begin
        busy <= 1'b1;
        cnt  <= '0;
        held <= PAD_W'({merged, {(PAD_W - HDR_W){1'b0}}});
      end
    end else if (src_ready) begin
      if (cnt == LAST) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= (32'(reg_addr) < NF) ? regs[reg_addr] : '0;
  end

  assign hdr_ready = !busy;
  assign src_valid = busy;
  assign src_data  = words[cnt];
  assign src_sop   = busy && cnt == '0;
  assign src_eop   = busy && cnt == LAST;
endmodule

module hdr_word_serializer_chk #(
  parameter int DATA_W  = 16,
  parameter int FIELD_W = 10,
  parameter int NF      = 4,
  parameter logic [NF-1:0] SRC_MASK = 4'b1010,
  parameter int AW      = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              hdr_valid,
  input logic              hdr_ready,
  input logic              reg_rd,
  input logic [AW-1:0]     reg_addr,
  input logic [FIELD_W-1:0] reg_rdata,
  input logic [DATA_W-1:0] src_data,
  input logic              src_valid,
  input logic              src_ready,
  input logic              src_sop,
  input logic              src_eop
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> !src_valid && hdr_ready && reg_rdata == '0);

  assert_start_after_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    hdr_valid && hdr_ready |=> src_valid && src_sop);

  assert_eop_ends_frame_R3: assert property (@(posedge clk) disable iff (rst)
    src_valid && src_ready && src_eop |=> !src_valid);

  assert_mid_frame_R3: assert property (@(posedge clk) disable iff (rst)
    src_valid && src_ready && !src_eop |=> src_valid && !src_sop);

  assert_hold_on_stall_R5: assert property (@(posedge clk) disable iff (rst)
    src_valid && !src_ready |=> src_valid && $stable(src_data) && $stable(src_sop) && $stable(src_eop));

  assert_no_ready_busy_R6: assert property (@(posedge clk) disable iff (rst)
    src_valid |-> !hdr_ready);

  assert_dp_field_reads_zero_R8: assert property (@(posedge clk) disable iff (rst)
    reg_rd && 32'(reg_addr) < NF && !SRC_MASK[reg_addr] |=> reg_rdata == '0);
endmodule

bind hdr_word_serializer hdr_word_serializer_chk #(
  .DATA_W(DATA_W), .FIELD_W(FIELD_W), .NF(NF), .SRC_MASK(SRC_MASK), .AW(AW)
) u_chk (.*);

// File: tb/sim_hdr_word_serializer.sv
module sim_hdr_word_serializer;
  localparam int DW = 16, FW = 10, NF = 4, HW = 40, NW = 3;
  localparam logic [3:0] MASK = 4'b1010;

  logic clk = 0, rst = 1;
  logic [HW-1:0] hdr_in = '0;
  logic hdr_valid = 0, hdr_ready;
  logic reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_addr = '0;
  logic [FW-1:0] reg_wdata = '0, reg_rdata;
  logic [DW-1:0] src_data;
  logic src_valid, src_ready = 1, src_sop, src_eop;

  int n_chk = 0, n_fail = 0;
  logic [FW-1:0] model_reg [NF];

  always #2 clk = ~clk;

  hdr_word_serializer u0 (.*);

  localparam logic [HW-1:0] TV [5] = '{
    40'h12_3456_789A, 40'hFF_FFFF_FFFF, 40'h00_0000_0000, 40'hA5_5A5A_A5A5, 40'h01_8040_2010};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_word(input logic [HW-1:0] h, input int k);
    logic [NW*DW-1:0] pad;
    logic [HW-1:0] v;
    for (int i = 0; i < NF; i++)
      v[HW-1-i*FW -: FW] = MASK[i] ? model_reg[i] : h[HW-1-i*FW -: FW];
    pad = {v, 8'h00};
    return pad[NW*DW-1-k*DW -: DW];
  endfunction

  task automatic strobe(input logic [HW-1:0] h);
    hdr_in = h; hdr_valid = 1;
    @(negedge clk);
    hdr_valid = 0;
  endtask

  task automatic collect(input logic [HW-1:0] h, input string req);
    for (int k = 0; k < NW; k++) begin
      chk(req, {63'd0, src_valid}, 64'd1);
      chk(req, {48'd0, src_data}, {48'd0, exp_word(h, k)});
      chk("R3", {62'd0, src_sop, src_eop}, {62'd0, k == 0, k == NW-1});
      @(negedge clk);
    end
    chk("R3", {63'd0, src_valid}, 64'd0);
  endtask

  task automatic wr(input int a, input logic [FW-1:0] d);
    reg_wr = 1; reg_addr = 2'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
    if (MASK[a]) model_reg[a] = d;
  endtask

  task automatic rd(input int a, input string req);
    reg_rd = 1; reg_addr = 2'(a);
    @(negedge clk);
    reg_rd = 0;
    chk(req, {54'd0, reg_rdata}, {54'd0, model_reg[a]});
  endtask

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < NF; i++) model_reg[i] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    chk("R1", {63'd0, src_valid}, 64'd0);
    chk("R1", {63'd0, hdr_ready}, 64'd1);
    chk("R1", {54'd0, reg_rdata}, 64'd0);
    for (int a = 0; a < NF; a++) rd(a, "R1");

    // R7, R8: register access
    wr(1, 10'h2AB);
    wr(3, 10'h155);
    wr(0, 10'h3FF);
    wr(2, 10'h111);
    for (int a = 0; a < NF; a++) rd(a, (MASK[a] ? "R7" : "R8"));

    // R2, R3, R4: table of headers at full rate
    for (int t = 0; t < 5; t++) begin
      strobe(TV[t]);
      collect(TV[t], "R4");
    end

    // R5, R6, R9: stall, stray strobe, register write mid-frame
    src_ready = 0;
    strobe(TV[0]);
    chk("R6", {63'd0, hdr_ready}, 64'd0);
    hdr_in = TV[1]; hdr_valid = 1;
    @(negedge clk);
    hdr_valid = 0;
    reg_wr = 1; reg_addr = 2'd1; reg_wdata = 10'h0F0;
    @(negedge clk);
    reg_wr = 0;
    chk("R5", {48'd0, src_data}, {48'd0, exp_word(TV[0], 0)});
    chk("R5", {62'd0, src_valid, src_sop}, 64'd3);
    src_ready = 1;
    @(negedge clk);
    src_ready = 0;
    @(negedge clk);
    chk("R5", {48'd0, src_data}, {48'd0, exp_word(TV[0], 1)});
    chk("R5", {62'd0, src_sop, src_eop}, 64'd0);
    src_ready = 1;
    @(negedge clk);
    chk("R9", {48'd0, src_data}, {48'd0, exp_word(TV[0], 2)});
    chk("R3", {63'd0, src_eop}, 64'd1);
    @(negedge clk);
    chk("R6", {62'd0, src_valid, hdr_ready}, 64'd1);
    model_reg[1] = 10'h0F0;
    rd(1, "R9");
    strobe(TV[3]);
    collect(TV[3], "R9");

    // R1: reset mid-frame
    src_ready = 0;
    strobe(TV[4]);
    rst = 1;
    @(negedge clk);
    rst = 0;
    for (int i = 0; i < NF; i++) model_reg[i] = '0;
    chk("R1", {62'd0, src_valid, hdr_ready}, 64'd1);
    rd(3, "R1");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule